// File: doc/BRIEF.md
# Latency-Insensitive Wrapper for a Small Synchronous Machine

This block turns a fixed synchronous machine into a dataflow node whose every port is a valid/ready channel. The machine keeps an 8-bit accumulator `acc`. It reads two 8-bit operands, `a` and `b`. It produces two results: `x = a + acc`, which depends only on `a` and the accumulator, and `y = a ^ b ^ acc`, which depends on both operands. At the end of each logical step the accumulator becomes `acc + a + b`. Each operand and each result passes through its own small FIFO. The n-th operand pair accepted forms logical step n, and the n-th value leaving each result channel belongs to step n. Any added latency or stall on a channel therefore changes when a result appears, but never what it is.

Each result has a sent flag. A result is produced once per step, as soon as the operands it actually depends on are at the heads of their FIFOs and its output FIFO has room. An `x` result never waits for `b`. Once both results of a step have been sent, a separate commit action fires. It needs both operand FIFOs non-empty. It updates the accumulator, pops one entry from each operand FIFO and clears both flags. Because every step whose results have all been sent also consumes its operands, networks built from such nodes drain cleanly.

Top module: `li_acc_node`

## Requirements
- R1: After reset the accumulator is 0, both sent flags are clear and all four FIFOs are empty: `a_ready` and `b_ready` are 1, and `x_valid` and `y_valid` are 0.
- R2: Each operand channel accepts a value (`*_valid` and `*_ready` both high at a clock edge) while its FIFO holds fewer than DEPTH (4) entries. Its ready is low while the FIFO holds 4 entries.
- R3: The n-th value on the x channel equals (a[n] + acc[n]) mod 256. Here a[n] is the n-th accepted `a` operand and acc[n] is the accumulator value at the start of step n.
- R4: The n-th value on the y channel equals a[n] XOR b[n] XOR acc[n].
- R5: acc[0] = 0 and acc[n+1] = (acc[n] + a[n] + b[n]) mod 256.
- R6: An x result is produced while `a` is present and `b` is absent. The y result waits for both operands.
- R7: Exactly one x result and one y result are produced per logical step, however long the step waits for its other operand.
- R8: The accumulator changes only in a commit cycle, which follows both results of the step having been sent. No result is produced in the same clock cycle as a commit.
- R9: Each result FIFO holds up to 4 values under back-pressure and delivers them in step order. With both result channels blocked, the node accepts exactly 8 operand pairs beyond those already committed and drained.
- R10: Once every result has been drained, all operands have been consumed: both operand channels are ready again and neither result channel is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Operand a offered |
| a_ready | output | 1 | Operand a FIFO has room |
| a_data | input | 8 | Operand a value |
| b_valid | input | 1 | Operand b offered |
| b_ready | output | 1 | Operand b FIFO has room |
| b_data | input | 8 | Operand b value |
| x_valid | output | 1 | x result available |
| x_ready | input | 1 | Consumer takes x |
| x_data | output | 8 | x result value |
| y_valid | output | 1 | y result available |
| y_ready | input | 1 | Consumer takes y |
| y_data | output | 8 | y result value |

## Verification
An operand accepted at an edge reaches its FIFO head at that edge. A result can be enqueued at the next edge at the earliest and is visible on `*_valid`/`*_data` at the following falling edge. A commit takes one more edge after both flags are set. Since correctness is defined by order and not by cycle, the bench compares each result as it is taken against the reference sequence, indexed by how many results that channel has delivered. It drives and samples only at falling edges, where ready and valid depend on FIFO occupancy alone. The directed phases wait a generous number of cycles before checking a settled condition: a lone x result, a blocked y, full FIFOs, or an empty node after draining.

// File: rtl/li_acc_node.sv
module li_acc_node #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] a_data,
  input  logic         b_valid,
  output logic         b_ready,
  input  logic [W-1:0] b_data,
  output logic         x_valid,
  input  logic         x_ready,
  output logic [W-1:0] x_data,
  output logic         y_valid,
  input  logic         y_ready,
  output logic [W-1:0] y_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NCH = 4;  // 0:a 1:b 2:x 3:y

  logic [NCH-1:0] push, pop;
  logic [W-1:0]   din  [NCH];
  logic [W-1:0]   head [NCH];
  logic [CW-1:0]  cnt  [NCH];

  logic [W-1:0] acc;
  logic         sent_x, sent_y;
  logic         fire_x, fire_y, commit;

  for (genvar g = 0; g < NCH; g++) begin : ch
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] n;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
        n  <= '0;
      end else begin
        if (push[g]) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop[g])  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        n <= n + CW'(push[g]) - CW'(pop[g]);
      end
    end

    always_ff @(posedge clk)
      if (push[g]) mem[wp] <= din[g];

    assign head[g] = mem[rp];
    assign cnt[g]  = n;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      n <= CW'(DEPTH));
  end

  wire a_have = cnt[0] != '0;
  wire b_have = cnt[1] != '0;

  assign a_ready = cnt[0] != CW'(DEPTH);
  assign b_ready = cnt[1] != CW'(DEPTH);
  assign x_valid = cnt[2] != '0;
  assign y_valid = cnt[3] != '0;
  assign x_data  = head[2];
  assign y_data  = head[3];

  assign fire_x = !sent_x && a_have && cnt[2] != CW'(DEPTH);
  assign fire_y = !sent_y && a_have && b_have && cnt[3] != CW'(DEPTH);
  assign commit = sent_x && sent_y && a_have && b_have;

  assign din[0] = a_data;
  assign din[1] = b_data;
  assign din[2] = head[0] + acc;
  assign din[3] = head[0] ^ head[1] ^ acc;

  assign push = {fire_y, fire_x, b_valid && b_ready, a_valid && a_ready};
  assign pop  = {y_valid && y_ready, x_valid && x_ready, commit, commit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      sent_x <= 1'b0;
      sent_y <= 1'b0;
    end else if (commit) begin
      acc    <= acc + head[0] + head[1];
      sent_x <= 1'b0;
      sent_y <= 1'b0;
    end else begin
      if (fire_x) sent_x <= 1'b1;
      if (fire_y) sent_y <= 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc == '0 && !sent_x && !sent_y));

  assert_acc_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> acc == W'($past(acc) + $past(head[0]) + $past(head[1])));

  assert_x_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sent_x && a_have && cnt[2] != CW'(DEPTH)) |=> (sent_x && cnt[2] != '0));

  assert_once_per_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[2] > $past(cnt[2])) |-> !$past(sent_x));

  assert_commit_after_sends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc) |-> $past(sent_x && sent_y));

  assert_no_fire_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !(fire_x || fire_y));
endmodule

// File: tb/li_acc_node_test.sv
`timescale 1ns/1ps
module li_acc_node_test;
  localparam int N = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, b_valid = 0, x_ready = 0, y_ready = 0;
  logic [7:0] a_data = 0, b_data = 0;
  logic a_ready, b_ready, x_valid, y_valid;
  logic [7:0] x_data, y_data;

  always #2.5 clk = ~clk;

  li_acc_node uut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
    .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data));

  logic [7:0] a_mem [N];
  logic [7:0] b_mem [N];
  logic [7:0] ex [N];
  logic [7:0] ey [N];

  int checks = 0, errors = 0, cycles = 0;
  int a_idx = 0, b_idx = 0, x_idx = 0, y_idx = 0;
  int a_lim = 0, b_lim = 0;
  int a_pct = 0, b_pct = 0, x_pct = 0, y_pct = 0;
  bit go = 0;

  always @(posedge clk) cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void build_reference();
    logic [7:0] s = 8'd0;
    for (int i = 0; i < N; i++) begin
      a_mem[i] = 8'($urandom);
      b_mem[i] = 8'($urandom);
      ex[i] = a_mem[i] + s;
      ey[i] = a_mem[i] ^ b_mem[i] ^ s;
      s = s + a_mem[i] + b_mem[i];
    end
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait (go);
    forever begin
      @(negedge clk);
      if (a_idx < a_lim && int'($urandom % 100) < a_pct) begin
        a_valid = 1; a_data = a_mem[a_idx];
        if (a_ready) a_idx++;
      end else a_valid = 0;
    end
  end

  initial begin
    wait (go);
    forever begin
      @(negedge clk);
      if (b_idx < b_lim && int'($urandom % 100) < b_pct) begin
        b_valid = 1; b_data = b_mem[b_idx];
        if (b_ready) b_idx++;
      end else b_valid = 0;
    end
  end

  initial begin
    wait (go);
    forever begin
      @(negedge clk);
      x_ready = int'($urandom % 100) < x_pct;
      if (x_ready && x_valid && x_idx < N) begin
        check(x_data == ex[x_idx], "R3 R5 x value", x_data, ex[x_idx]);
        x_idx++;
      end
    end
  end

  initial begin
    wait (go);
    forever begin
      @(negedge clk);
      y_ready = int'($urandom % 100) < y_pct;
      if (y_ready && y_valid && y_idx < N) begin
        check(y_data == ey[y_idx], "R4 R5 y value", y_data, ey[y_idx]);
        y_idx++;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    build_reference();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(a_ready && b_ready, "R1 inputs ready", {a_ready, b_ready}, 3);
    check(!x_valid && !y_valid, "R1 outputs empty", {x_valid, y_valid}, 0);
    rst_n = 1'b1;
    go = 1;

    // R6/R7: only a present
    a_lim = 1; a_pct = 100; x_pct = 100;
    idle(10);
    check(x_idx == 1, "R6 x produced without b", x_idx, 1);
    check(!x_valid, "R7 single x per step", x_valid, 0);
    check(!y_valid, "R6 y waits for b", y_valid, 0);
    check(a_idx == 1, "R8 no commit without b", a_idx, 1);
    b_lim = 1; b_pct = 100;
    idle(10);
    check(y_valid && y_data == ey[0], "R4 y after b", y_data, ey[0]);
    y_pct = 100;
    idle(5);
    check(y_idx == 1, "R7 single y per step", y_idx, 1);

    // R2/R9: blocked results
    x_pct = 0; y_pct = 0;
    idle(2);
    a_lim = 21; b_lim = 21;
    idle(40);
    check(a_idx == 9, "R9 operands accepted under back-pressure", a_idx, 9);
    check(b_idx == 9, "R9 b operands accepted", b_idx, 9);
    check(!a_ready && !b_ready, "R2 ready low when full", {a_ready, b_ready}, 0);
    check(x_valid && x_data == ex[1], "R9 head of x FIFO", x_data, ex[1]);
    x_pct = 100; y_pct = 100;
    idle(80);
    check(x_idx == 21 && y_idx == 21, "R9 drained in order", x_idx + y_idx, 42);
    check(a_ready && b_ready && !x_valid && !y_valid, "R10 node empty",
          {a_ready, b_ready, x_valid, y_valid}, 12);

    // random stalls on all channels
    a_lim = N; b_lim = N;
    for (int ph = 0; ph < 8; ph++) begin
      a_pct = 20 + int'($urandom % 80); b_pct = 20 + int'($urandom % 80);
      x_pct = 20 + int'($urandom % 80); y_pct = 20 + int'($urandom % 80);
      idle(400);
    end
    a_pct = 100; b_pct = 100; x_pct = 100; y_pct = 100;
    while ((x_idx < N || y_idx < N) && cycles < 150000) @(negedge clk);
    if (x_idx < N || y_idx < N) begin
      check(0, "watchdog", x_idx + y_idx, 2 * N);
    end else begin
      idle(5);
      check(a_idx == N && b_idx == N, "R10 all operands consumed", a_idx + b_idx, 2 * N);
      check(a_ready && b_ready && !x_valid && !y_valid, "R10 empty after run",
            {a_ready, b_ready, x_valid, y_valid}, 12);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule